// File: doc/BRIEF.md
# Memory Protection Access Checker

This block decides, for every bus access, whether the access may proceed under the current memory protection settings. Each access gives an address, a kind (read, write or instruction fetch), a privilege flag and a flag that marks accesses made from fault-level handlers. The block compares the address with a set of programmable regions. Each region has a power-of-two size, a base address, eight subregions that can be switched off one by one, a 3-bit permission code, a no-execute flag and an enable bit. Global control inputs turn checking on or off, decide whether fault-level handlers are checked, and decide whether privileged accesses that match no region fall back to a permissive background map.

The verdict is registered. A verdict state register holds one of three states. `V_IDLE` means there is no result. `V_PERMIT` means the last access is allowed. `V_FAULT` means the last access is refused. On every clock edge the state moves to `V_IDLE` when no access is offered (transition GAP). It moves to `V_PERMIT` when the offered access is allowed (transition ALLOW). It moves to `V_FAULT` when the access is refused (transition DENY). Any state can take any of these transitions. Reset puts the register in `V_IDLE`. The number of the deciding region is registered next to the verdict.

Top module: `mpc_access_check`

## Requirements
- R1: A verdict is shown on `res_valid`/`res_permit`/`res_fault` in the cycle after `acc_valid` is sampled high. After a cycle with `acc_valid` low, and after reset, `res_valid`, `res_permit`, `res_fault` and `res_hit` are all 0.
- R2: With `ctl_enable` low, every access is permitted, `res_hit` is 0 and `res_region` is 0.
- R3: With `ctl_guard_handlers` low, an access with `acc_handler` high is permitted with `res_hit` 0. With `ctl_guard_handlers` high, the same access is checked like any other.
- R4: Region i covers 2^(size+1) bytes, where size is `rg_size[5i+4:5i]`. The base is `rg_base[AW*i +: AW]`. Base bits below the span are ignored. A size value below 4 never matches.
- R5: For a size of 7 or more, address bits [size:size-2] select one of eight subregions. Setting bit k of `rg_srd[8i +: 8]` removes subregion k from the match. For smaller sizes the disable field is ignored.
- R6: A region whose `rg_en[i]` bit is 0 never matches.
- R7: When several regions match, the highest-numbered region decides the result and is reported on `res_region` with `res_hit` 1.
- R8: The permission code `rg_ap[3i +: 3]` works as follows. 0 refuses everything. 1 allows privileged read/write only. 2 allows privileged read/write and unprivileged read. 3 allows everything.
- R9: Permission code 5 allows only privileged reads. Code 6 allows reads at either privilege and refuses all writes. Codes 4 and 7 refuse everything.
- R10: `acc_kind` encoding: 2'b00 is a read, 2'b01 is a write, 2'b1x is a fetch. A fetch is checked as a read, and a fetch is also refused when `rg_xn[i]` of the deciding region is 1.
- R11: An access that matches no region is permitted only if it is privileged and `ctl_priv_background` is 1. Otherwise it faults. In both cases `res_hit` is 0 and `res_region` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Global checking enable |
| ctl_guard_handlers | input | 1 | 1: accesses from fault-level handlers are checked |
| ctl_priv_background | input | 1 | 1: privileged accesses with no region match are permitted |
| acc_valid | input | 1 | An access is offered this cycle |
| acc_addr | input | AW | Access address |
| acc_kind | input | 2 | 00 read, 01 write, 1x fetch |
| acc_priv | input | 1 | Access is privileged |
| acc_handler | input | 1 | Access comes from a fault-level handler |
| rg_base | input | NREG*AW | Region base addresses |
| rg_size | input | NREG*5 | Region size codes |
| rg_srd | input | NREG*8 | Subregion disable masks |
| rg_ap | input | NREG*3 | Permission codes |
| rg_xn | input | NREG | No-execute flags |
| rg_en | input | NREG | Region enable bits |
| res_valid | output | 1 | A verdict is present |
| res_permit | output | 1 | The access is allowed |
| res_fault | output | 1 | The access is refused |
| res_hit | output | 1 | A region decided the verdict |
| res_region | output | $clog2(NREG) | Number of the deciding region |

## Verification
The assertions assume that the region settings and control inputs in a cycle are the ones meant to apply to the access sampled in that cycle. They also assume that the enable mask seen one edge earlier is the one that governed the reported region. The stimulus changes configuration only at the falling edge, together with the access it applies to, and holds it steady across the capturing edge. Region bases in the stimulus are aligned, except for one region whose base deliberately carries low bits that must be ignored.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    localparam int SIZE_W       = 5;
    localparam int SRD_W        = 8;
    localparam int AP_W         = 3;
    localparam int MIN_SIZE     = 4;
    localparam int SUB_MIN_SIZE = 7;

    typedef enum logic [1:0] {
        V_IDLE   = 2'd0,
        V_PERMIT = 2'd1,
        V_FAULT  = 2'd2
    } verdict_e;

    // Permission decode: fetches arrive here as reads.
    function automatic logic ap_allows(input logic [AP_W-1:0] ap,
                                       input logic priv,
                                       input logic wr);
        logic ok;
        unique case (ap)
            3'd1:    ok = priv;
            3'd2:    ok = priv | ~wr;
            3'd3:    ok = 1'b1;
            3'd5:    ok = priv & ~wr;
            3'd6:    ok = ~wr;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/mpc_region_match.sv
module mpc_region_match
    import mpc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]     addr,
    input  logic [AW-1:0]     base,
    input  logic [SIZE_W-1:0] size,
    input  logic [SRD_W-1:0]  srd,
    input  logic              en,
    output logic              hit
);
    logic [5:0]    span_lg;
    logic [5:0]    sub_shift;
    logic [AW-1:0] diff;
    logic          in_range;
    logic          size_ok;
    logic          sub_on;
    logic [2:0]    sub_idx;

    always_comb begin
        span_lg   = {1'b0, size} + 6'd1;
        sub_shift = {1'b0, size} - 6'd2;
        diff      = addr ^ base;
        in_range  = (diff >> span_lg) == '0;
        size_ok   = size >= SIZE_W'(MIN_SIZE);
        sub_on    = size >= SIZE_W'(SUB_MIN_SIZE);
        sub_idx   = 3'(addr >> sub_shift);
        hit       = en & size_ok & in_range & ~(sub_on & srd[sub_idx]);
    end

endmodule

// File: rtl/mpc_prio_pick.sv
module mpc_prio_pick #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/mpc_perm_eval.sv
module mpc_perm_eval
    import mpc_pkg::*;
(
    input  logic [AP_W-1:0] ap,
    input  logic            xn,
    input  logic            priv,
    input  logic [1:0]      kind,
    output logic            allow
);
    logic is_fetch;
    logic is_write;

    always_comb begin
        is_fetch = kind[1];
        is_write = (kind == 2'b01);
        allow    = ap_allows(ap, priv, is_write) & ~(is_fetch & xn);
    end

endmodule

// File: rtl/mpc_access_check.sv
module mpc_access_check
    import mpc_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 32,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_enable,
    input  logic                   ctl_guard_handlers,
    input  logic                   ctl_priv_background,
    input  logic                   acc_valid,
    input  logic [AW-1:0]          acc_addr,
    input  logic [1:0]             acc_kind,
    input  logic                   acc_priv,
    input  logic                   acc_handler,
    input  logic [NREG*AW-1:0]     rg_base,
    input  logic [NREG*SIZE_W-1:0] rg_size,
    input  logic [NREG*SRD_W-1:0]  rg_srd,
    input  logic [NREG*AP_W-1:0]   rg_ap,
    input  logic [NREG-1:0]        rg_xn,
    input  logic [NREG-1:0]        rg_en,
    output logic                   res_valid,
    output logic                   res_permit,
    output logic                   res_fault,
    output logic                   res_hit,
    output logic [IW-1:0]          res_region
);
    logic [NREG-1:0] hits;
    logic            any_hit;
    logic [IW-1:0]   pick;
    logic [AP_W-1:0] sel_ap;
    logic            sel_xn;
    logic            region_allow;
    logic            bypass;
    logic            allow;
    logic            use_hit;
    verdict_e        state_q, state_d;
    logic            hit_q;
    logic [IW-1:0]   region_q;

    for (genvar g = 0; g < NREG; g++) begin : g_region
        mpc_region_match #(.AW(AW)) u_match (
            .addr (acc_addr),
            .base (rg_base[g*AW +: AW]),
            .size (rg_size[g*SIZE_W +: SIZE_W]),
            .srd  (rg_srd[g*SRD_W +: SRD_W]),
            .en   (rg_en[g]),
            .hit  (hits[g])
        );
    end

    mpc_prio_pick #(.N(NREG)) u_pick (
        .hits (hits),
        .any  (any_hit),
        .idx  (pick)
    );

    always_comb begin
        sel_ap = rg_ap[pick*AP_W +: AP_W];
        sel_xn = rg_xn[pick];
    end

    mpc_perm_eval u_perm (
        .ap    (sel_ap),
        .xn    (sel_xn),
        .priv  (acc_priv),
        .kind  (acc_kind),
        .allow (region_allow)
    );

    // Decision and next-state selection (GAP / ALLOW / DENY).
    always_comb begin
        bypass = ~ctl_enable | (acc_handler & ~ctl_guard_handlers);
        if (bypass) begin
            allow   = 1'b1;
            use_hit = 1'b0;
        end else if (any_hit) begin
            allow   = region_allow;
            use_hit = 1'b1;
        end else begin
            allow   = acc_priv & ctl_priv_background;
            use_hit = 1'b0;
        end
        if (!acc_valid)  state_d = V_IDLE;
        else if (allow)  state_d = V_PERMIT;
        else             state_d = V_FAULT;
    end

    // State register with the deciding region alongside.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= V_IDLE;
            hit_q    <= 1'b0;
            region_q <= '0;
        end else begin
            state_q  <= state_d;
            hit_q    <= acc_valid & use_hit;
            region_q <= (acc_valid & use_hit) ? pick : '0;
        end
    end

    // Output decode from the verdict state.
    always_comb begin
        res_valid  = 1'b0;
        res_permit = 1'b0;
        res_fault  = 1'b0;
        unique case (state_q)
            V_IDLE:   ;
            V_PERMIT: begin res_valid = 1'b1; res_permit = 1'b1; end
            V_FAULT:  begin res_valid = 1'b1; res_fault  = 1'b1; end
            default:  ;
        endcase
        res_hit    = hit_q;
        res_region = region_q;
    end

endmodule

// File: rtl/mpc_access_check_sva.sv
module mpc_access_check_sva #(
    parameter int NREG = 8,
    parameter int AW   = 32,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctl_enable,
    input logic            ctl_guard_handlers,
    input logic            ctl_priv_background,
    input logic            acc_valid,
    input logic            acc_priv,
    input logic            acc_handler,
    input logic [NREG-1:0] rg_en,
    input logic            res_valid,
    input logic            res_permit,
    input logic            res_hit,
    input logic [IW-1:0]   res_region
);
    logic [NREG-1:0] en_q;
    logic            checked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= rg_en;
    end

    always_comb checked = ctl_enable & ~(acc_handler & ~ctl_guard_handlers);

    assert_gap_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid && !res_hit);

    assert_result_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);

    assert_global_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !ctl_enable |=> res_permit && !res_hit && res_region == '0);

    assert_handler_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && ctl_enable && acc_handler && !ctl_guard_handlers |=> res_permit && !res_hit);

    assert_hit_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> en_q[res_region]);

    assert_nomatch_rule_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && checked && rg_en == '0
        |=> !res_hit && res_permit == $past(acc_priv && ctl_priv_background));

endmodule

bind mpc_access_check mpc_access_check_sva #(.NREG(NREG), .AW(AW)) u_sva (
    .clk                 (clk),
    .rst_n               (rst_n),
    .ctl_enable          (ctl_enable),
    .ctl_guard_handlers  (ctl_guard_handlers),
    .ctl_priv_background (ctl_priv_background),
    .acc_valid           (acc_valid),
    .acc_priv            (acc_priv),
    .acc_handler         (acc_handler),
    .rg_en               (rg_en),
    .res_valid           (res_valid),
    .res_permit          (res_permit),
    .res_hit             (res_hit),
    .res_region          (res_region)
);

// File: tb/mpc_access_check_test.sv
`timescale 1ns/1ps
module mpc_access_check_test;
    localparam int NREG = 8;
    localparam int AW   = 32;
    localparam int IW   = 3;
    localparam logic [1:0] K_RD = 2'b00, K_WR = 2'b01, K_FE = 2'b10;

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  kind;
        logic        priv, hnd, en, gh, bg;
        logic        efault, ehit;
        logic [2:0]  ereg;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{32'h0001_0000, K_RD, 0,0,1,1,0, 0,1,3'd0, 4'd4 },  // R4 inside 1MB region 0
        '{32'h000F_FFFC, K_WR, 0,0,1,1,0, 0,1,3'd0, 4'd4 },  // R4 last word of region 0
        '{32'h0010_0000, K_RD, 1,0,1,1,0, 1,0,3'd0, 4'd11},  // R11 no match, no background
        '{32'h0010_0000, K_RD, 1,0,1,1,1, 0,0,3'd0, 4'd11},  // R11 privileged background
        '{32'h0010_0000, K_RD, 0,0,1,1,1, 1,0,3'd0, 4'd11},  // R11 unprivileged no match
        '{32'h0000_8010, K_WR, 0,0,1,1,0, 1,1,3'd3, 4'd9 },  // R9 code 6 write
        '{32'h0000_8010, K_RD, 0,0,1,1,0, 0,1,3'd3, 4'd7 },  // R7 region 3 over region 0
        '{32'h0000_9000, K_WR, 0,0,1,1,0, 0,1,3'd0, 4'd7 },  // R7 past region 3
        '{32'h2000_7FF0, K_RD, 0,0,1,1,0, 0,1,3'd1, 4'd8 },  // R8 code 2 user read, R4 base low bits
        '{32'h2000_0004, K_WR, 0,0,1,1,0, 1,1,3'd1, 4'd8 },  // R8 code 2 user write
        '{32'h2000_0004, K_WR, 1,0,1,1,0, 0,1,3'd1, 4'd8 },  // R8 code 2 priv write
        '{32'h2000_0004, K_FE, 1,0,1,1,0, 1,1,3'd1, 4'd10},  // R10 fetch from no-execute
        '{32'h0000_0100, K_FE, 0,0,1,1,0, 0,1,3'd0, 4'd10},  // R10 fetch allowed
        '{32'h4000_0200, K_RD, 1,0,1,1,0, 0,1,3'd2, 4'd8 },  // R8 code 1 priv
        '{32'h4000_0200, K_RD, 0,0,1,1,0, 1,1,3'd2, 4'd8 },  // R8 code 1 user
        '{32'h4000_0C00, K_RD, 1,0,1,1,0, 1,0,3'd0, 4'd5 },  // R5 subregion 6 off
        '{32'h4000_0BFC, K_RD, 1,0,1,1,0, 0,1,3'd2, 4'd5 },  // R5 subregion 5 on
        '{32'h4000_0E00, K_RD, 1,0,1,1,1, 0,0,3'd0, 4'd5 },  // R5 subregion 7 off, background
        '{32'h5000_001C, K_RD, 1,0,1,1,0, 0,1,3'd4, 4'd5 },  // R5 mask ignored on 32B region
        '{32'h5000_001C, K_WR, 1,0,1,1,0, 1,1,3'd4, 4'd9 },  // R9 code 5 write
        '{32'h5000_0000, K_FE, 0,0,1,1,0, 1,1,3'd4, 4'd9 },  // R9 code 5 user fetch
        '{32'h5000_0020, K_RD, 1,0,1,1,0, 1,0,3'd0, 4'd4 },  // R4 past 32B span
        '{32'h6000_0000, K_RD, 1,0,1,1,0, 1,0,3'd0, 4'd4 },  // R4 reserved size
        '{32'h7000_0010, K_RD, 1,0,1,1,0, 1,1,3'd6, 4'd6 },  // R6 region 7 off, region 6 code 0
        '{32'h2000_0004, K_WR, 0,0,0,1,0, 0,0,3'd0, 4'd2 },  // R2 global off
        '{32'h2000_0004, K_WR, 0,1,1,0,0, 0,0,3'd0, 4'd3 },  // R3 handler bypass
        '{32'h2000_0004, K_WR, 0,1,1,1,0, 1,1,3'd1, 4'd3 },  // R3 handler checked
        '{32'h0010_0000, K_RD, 0,1,1,0,0, 0,0,3'd0, 4'd3 },  // R3 bypass beats no-match
        '{32'h0000_8010, K_FE, 1,0,1,1,0, 0,1,3'd3, 4'd10}   // R10 fetch as read
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctl_enable = 0, ctl_guard_handlers = 0, ctl_priv_background = 0;
    logic acc_valid = 0, acc_priv = 0, acc_handler = 0;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0] acc_kind = '0;
    logic [NREG*AW-1:0] rg_base = '0;
    logic [NREG*5-1:0]  rg_size = '0;
    logic [NREG*8-1:0]  rg_srd  = '0;
    logic [NREG*3-1:0]  rg_ap   = '0;
    logic [NREG-1:0]    rg_xn   = '0, rg_en = '0;
    logic res_valid, res_permit, res_fault, res_hit;
    logic [IW-1:0] res_region;
    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mpc_access_check #(.NREG(NREG), .AW(AW)) uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_region(input int i, input logic [31:0] b, input logic [4:0] s,
                              input logic [7:0] m, input logic [2:0] ap,
                              input logic xn, input logic en);
        rg_base[i*AW +: AW] = b;
        rg_size[i*5 +: 5]   = s;
        rg_srd[i*8 +: 8]    = m;
        rg_ap[i*3 +: 3]     = ap;
        rg_xn[i]            = xn;
        rg_en[i]            = en;
    endtask

    function automatic logic [31:0] pack_res(input logic v, p, f, h, input logic [2:0] r);
        return {25'd0, v, p, f, h, r};
    endfunction

    task automatic access(input logic [31:0] a, input logic [1:0] k, input logic pr, hd);
        @(negedge clk);
        acc_valid = 1; acc_addr = a; acc_kind = k; acc_priv = pr; acc_handler = hd;
        @(negedge clk);
    endtask

    initial begin
        #200_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        set_region(0, 32'h0000_0000, 5'h13, 8'h00, 3'd3, 0, 1);
        set_region(1, 32'h2000_0123, 5'h0E, 8'h00, 3'd2, 1, 1);
        set_region(2, 32'h4000_0000, 5'h0B, 8'hC0, 3'd1, 1, 1);
        set_region(3, 32'h0000_8000, 5'h0B, 8'h00, 3'd6, 0, 1);
        set_region(4, 32'h5000_0000, 5'h04, 8'hFF, 3'd5, 0, 1);
        set_region(5, 32'h6000_0000, 5'h03, 8'h00, 3'd3, 0, 1);
        set_region(6, 32'h7000_0000, 5'h09, 8'h00, 3'd0, 0, 1);
        set_region(7, 32'h7000_0000, 5'h09, 8'h00, 3'd3, 0, 0);
        acc_valid = 1; ctl_enable = 1;
        repeat (3) @(negedge clk);
        // R1: outputs held clear while in reset, even with an access offered
        check("R1 reset", pack_res(res_valid, res_permit, res_fault, res_hit, res_region), 32'd0);
        rst_n = 1; acc_valid = 0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            acc_valid = 1; acc_addr = VECS[v].addr; acc_kind = VECS[v].kind;
            acc_priv = VECS[v].priv; acc_handler = VECS[v].hnd;
            ctl_enable = VECS[v].en; ctl_guard_handlers = VECS[v].gh;
            ctl_priv_background = VECS[v].bg;
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VECS[v].rq, v),
                  pack_res(res_valid, res_permit, res_fault, res_hit, res_region),
                  pack_res(1'b1, ~VECS[v].efault, VECS[v].efault, VECS[v].ehit, VECS[v].ereg));
        end

        ctl_enable = 1; ctl_guard_handlers = 1; ctl_priv_background = 0;
        // R9: reserved codes 4 and 7 refuse a privileged read
        rg_ap[6*3 +: 3] = 3'd4;
        access(32'h7000_0010, K_RD, 1, 0);
        check("R9 code4", pack_res(res_valid, res_permit, res_fault, res_hit, res_region),
              pack_res(1, 0, 1, 1, 3'd6));
        rg_ap[6*3 +: 3] = 3'd7;
        access(32'h7000_0010, K_RD, 1, 0);
        check("R9 code7", pack_res(res_valid, res_permit, res_fault, res_hit, res_region),
              pack_res(1, 0, 1, 1, 3'd6));
        // R7: enabling region 7 lets it override region 6
        rg_en[7] = 1;
        access(32'h7000_0010, K_WR, 0, 0);
        check("R7 top wins", pack_res(res_valid, res_permit, res_fault, res_hit, res_region),
              pack_res(1, 1, 0, 1, 3'd7));
        // R6: both overlapping regions disabled, so no match remains
        rg_en[7] = 0; rg_en[6] = 0;
        access(32'h7000_0010, K_RD, 1, 0);
        check("R6 disabled", pack_res(res_valid, res_permit, res_fault, res_hit, res_region),
              pack_res(1, 0, 1, 0, 3'd0));
        // R1: a gap cycle clears the verdict
        @(negedge clk);
        acc_valid = 0;
        @(negedge clk);
        check("R1 gap", pack_res(res_valid, res_permit, res_fault, res_hit, res_region), 32'd0);
        // R1: no verdict before the capturing edge
        acc_valid = 1; acc_addr = 32'h0001_0000; acc_kind = K_RD; acc_priv = 0;
        #1;
        check("R1 latency", {31'd0, res_valid}, 32'd0);
        @(negedge clk);
        check("R1 verdict", pack_res(res_valid, res_permit, res_fault, res_hit, res_region),
              pack_res(1, 1, 0, 1, 3'd0));
        acc_valid = 0;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule